// File: doc/BRIEF.md
# Cosine Tone Generator (Phase-Accumulator Synthesis)

This block produces a periodic cosine waveform as an unsigned 8-bit code for a digital-to-analog converter. A 16-bit phase accumulator advances by a programmable step on every tick of a slowed-down clock. The upper eight accumulator bits select an entry of a cosine table. The tone frequency is therefore `f_clk / (div_sel + 1) * freq_step / 65536`. A 16-bit step can only place the tone on integer multiples of that base resolution. The clock divider moves the resolution grid, which gives finer control over where a tone can land.

Each table sample then passes through a fixed chain. It is negated when the 180-degree phase is selected. It is attenuated by an arithmetic right shift of 0 to 3 bits. A signed DC offset is added. The sum is clipped to the signed 8-bit range, and the sign bit is inverted so that the result is an offset-binary code. Every new code comes with a one-cycle valid strobe.

When the generator is disabled, the phase returns to zero and the output holds the code for the offset alone. Each enable therefore starts the waveform at its positive peak.

Top module: `cosgen_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `dac_code` is 128 (0x80) and `dac_valid` is 0.
- R2: While `enable` is low, each clock edge sets `dac_code` to the offset alone, clipped and sign-inverted (`{~dc_offset[7], dc_offset[6:0]}`), and drives `dac_valid` to 0. The phase is cleared to zero, so the first sample after enable comes from table index 0.
- R3: With `enable` high, `dac_valid` pulses for one cycle once every `div_sel + 1` clocks. The first pulse appears `div_sel + 1` clock edges after `enable` is first sampled high.
- R4: Sample n after enable (n = 0, 1, ...) is taken at phase P(n), the running sum of the steps applied at ticks 0..n-1, modulo 65536. The table index is P(n)[15:8]. A new `freq_step` is used from the next tick onward and does not reset the phase.
- R5: Table entry i equals round(127 * cos(2*pi*i/256)), rounded half away from zero. Index 0 is +127.
- R6: When `phase_inv` is 1, the table sample is negated before it is scaled (180-degree shift).
- R7: `scale_sel` values 0, 1, 2 and 3 apply an arithmetic right shift of 0, 1, 2 and 3 bits to the signed sample. 0 is loudest and 3 is quietest.
- R8: The scaled sample plus the signed `dc_offset` is clipped to -128..127. `dac_code` equals the clipped value + 128.
- R9: `freq_step`, `scale_sel`, `phase_inv` and `dc_offset` are sampled in the tick cycle. A change made between two ticks affects only the samples that follow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low clears the phase |
| freq_step | input | 16 | Phase increment per tick |
| div_sel | input | 3 | Tick interval minus one, in system clocks |
| scale_sel | input | 2 | Attenuation shift, 0..3 bits |
| phase_inv | input | 1 | 1 selects the 180-degree phase |
| dc_offset | input | 8 | Signed DC offset, -128..127 |
| dac_code | output | 8 | Unsigned offset-binary output code |
| dac_valid | output | 1 | One-cycle strobe for each new code |

## Verification
The hardest case to reach from the ports is a step change that falls between two ticks of a divided clock. The phase must keep its accumulated value and pick up the new increment only at the next tick. The stimulus waits for a valid strobe, changes the step and the offset in the gap, and compares every later sample with a phase model that runs in the bench. Both clipping rails are forced from vectors that pair a full-scale peak with an offset of the same sign.

// File: rtl/cosgen_pkg.sv
package cosgen_pkg;

    localparam int ACC_W  = 16;
    localparam int LUT_AW = 8;
    localparam int SMP_W  = 8;
    localparam int DIV_W  = 3;
    localparam int SCL_W  = 2;

    typedef enum logic {
        PH_0   = 1'b0,
        PH_180 = 1'b1
    } phase_e;

    typedef struct packed {
        logic [SCL_W-1:0]        shift;
        phase_e                  ph;
        logic signed [SMP_W-1:0] off;
    } shape_cfg_t;

    // Rounded cosine sample, half away from zero; used only at elaboration.
    function automatic int cos_entry(int idx, int aw, int amp);
        real ang;
        real v;
        ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(2 ** aw);
        v   = real'(amp) * $cos(ang);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/cosgen_tick_div.sv
module cosgen_tick_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_sel);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cosgen_phase_acc.sv
module cosgen_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase
);

    logic [ACC_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (adv) begin
            acc_q <= acc_q + step;
        end
    end

    assign phase = acc_q;

endmodule

// File: rtl/cosgen_cos_rom.sv
module cosgen_cos_rom
    import cosgen_pkg::*;
#(
    parameter int AW = 8,
    parameter int W  = 8
) (
    input  logic [AW-1:0]       idx,
    output logic signed [W-1:0] smp
);

    localparam int DEPTH = 2 ** AW;
    localparam int AMP   = (2 ** (W - 1)) - 1;

    logic signed [W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic signed [W-1:0] ENTRY = W'(cos_entry(g, AW, AMP));
        assign rom[g] = ENTRY;
    end

    assign smp = rom[idx];

endmodule

// File: rtl/cosgen_shaper.sv
module cosgen_shaper
    import cosgen_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = 2
) (
    input  logic signed [W-1:0] smp,
    input  logic [SW-1:0]       shift,
    input  phase_e              ph,
    input  logic signed [W-1:0] off,
    output logic [W-1:0]        code
);

    localparam logic signed [W:0] HI = (W+1)'((2 ** (W - 1)) - 1);
    localparam logic signed [W:0] LO = -(W+1)'(2 ** (W - 1));

    logic signed [W-1:0] s_ph;
    logic signed [W-1:0] s_sc;
    logic signed [W:0]   s_sum;
    logic signed [W-1:0] s_sat;

    always_comb begin
        s_ph  = (ph == PH_180) ? -smp : smp;
        s_sc  = s_ph >>> shift;
        s_sum = {s_sc[W-1], s_sc} + {off[W-1], off};
        if (s_sum > HI) begin
            s_sat = HI[W-1:0];
        end else if (s_sum < LO) begin
            s_sat = LO[W-1:0];
        end else begin
            s_sat = s_sum[W-1:0];
        end
        code = {~s_sat[W-1], s_sat[W-2:0]};
    end

endmodule

// File: rtl/cosgen_top.sv
module cosgen_top
    import cosgen_pkg::*;
#(
    parameter int ACC_BITS = ACC_W,
    parameter int IDX_BITS = LUT_AW,
    parameter int DIV_BITS = DIV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [ACC_BITS-1:0] freq_step,
    input  logic [DIV_BITS-1:0] div_sel,
    input  logic [SCL_W-1:0]    scale_sel,
    input  logic                phase_inv,
    input  logic [SMP_W-1:0]    dc_offset,
    output logic [SMP_W-1:0]    dac_code,
    output logic                dac_valid
);

    localparam logic [SMP_W-1:0] MID_CODE = SMP_W'(2 ** (SMP_W - 1));

    logic                    tick;
    logic [ACC_BITS-1:0]     phase;
    logic signed [SMP_W-1:0] rom_smp;
    logic signed [SMP_W-1:0] shp_in;
    logic [SMP_W-1:0]        shp_code;
    shape_cfg_t              cfg;
    logic [SMP_W-1:0]        code_q;
    logic                    valid_q;

    cosgen_tick_div #(.DIV_W(DIV_BITS)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (enable),
        .div_sel (div_sel),
        .tick    (tick)
    );

    cosgen_phase_acc #(.ACC_W(ACC_BITS)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (!enable),
        .adv   (tick),
        .step  (freq_step),
        .phase (phase)
    );

    cosgen_cos_rom #(.AW(IDX_BITS), .W(SMP_W)) u_rom (
        .idx (phase[ACC_BITS-1 -: IDX_BITS]),
        .smp (rom_smp)
    );

    always_comb begin
        cfg.shift = scale_sel;
        cfg.ph    = phase_inv ? PH_180 : PH_0;
        cfg.off   = $signed(dc_offset);
        shp_in    = enable ? rom_smp : '0;
    end

    cosgen_shaper #(.W(SMP_W), .SW(SCL_W)) u_shp (
        .smp   (shp_in),
        .shift (cfg.shift),
        .ph    (cfg.ph),
        .off   (cfg.off),
        .code  (shp_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= MID_CODE;
            valid_q <= 1'b0;
        end else if (!enable) begin
            code_q  <= shp_code;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tick;
            if (tick) begin
                code_q <= shp_code;
            end
        end
    end

    assign dac_code  = code_q;
    assign dac_valid = valid_q;

endmodule

// File: rtl/cosgen_chk.sv
module cosgen_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic [2:0] div_sel,
    input logic [1:0] scale_sel,
    input logic       phase_inv,
    input logic [7:0] dc_offset,
    input logic [7:0] dac_code,
    input logic       dac_valid
);

    p_idle_code_r2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (dac_code == {~$past(dc_offset[7]), $past(dc_offset[6:0])}) && !dac_valid);

    p_valid_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (dac_valid && div_sel != 3'd0) |=> !dac_valid);

    p_valid_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        dac_valid |-> $past(enable));

    p_quiet_span_r7: assert property (@(posedge clk) disable iff (rst)
        (dac_valid && $past(dc_offset) == 8'd0 && $past(scale_sel) == 2'd3)
        |-> (dac_code >= 8'd112 && dac_code <= 8'd143));

    p_clip_high_r8: assert property (@(posedge clk) disable iff (rst)
        (dac_valid && $past(dc_offset) == 8'd127 && $past(scale_sel) == 2'd0 && !$past(phase_inv))
        |-> dac_code >= 8'd128);

endmodule

bind cosgen_top cosgen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .div_sel   (div_sel),
    .scale_sel (scale_sel),
    .phase_inv (phase_inv),
    .dc_offset (dc_offset),
    .dac_code  (dac_code),
    .dac_valid (dac_valid)
);

// File: tb/sim_cosgen_top.sv
module sim_cosgen_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       enable;
    logic [15:0] freq_step;
    logic [2:0] div_sel;
    logic [1:0] scale_sel;
    logic       phase_inv;
    logic [7:0] dc_offset;
    logic [7:0] dac_code;
    logic       dac_valid;

    always #4 clk = ~clk;

    cosgen_top u0 (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .freq_step (freq_step),
        .div_sel   (div_sel),
        .scale_sel (scale_sel),
        .phase_inv (phase_inv),
        .dc_offset (dc_offset),
        .dac_code  (dac_code),
        .dac_valid (dac_valid)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct packed {
        logic [15:0] step;
        logic [2:0]  div;
        logic [1:0]  sc;
        logic        ph;
        logic [7:0]  off;
        logic [7:0]  first;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 3'd0, 2'd0, 1'b0, 8'd0,   8'd255},
        '{16'h0400, 3'd2, 2'd1, 1'b1, 8'd0,   8'd64},
        '{16'h1234, 3'd1, 2'd2, 1'b0, 8'd20,  8'd179},
        '{16'h8000, 3'd7, 2'd3, 1'b1, 8'hF6,  8'd102},
        '{16'h0080, 3'd0, 2'd0, 1'b0, 8'd100, 8'd255},
        '{16'h4000, 3'd3, 2'd0, 1'b1, 8'h9C,  8'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_code(int acc, int sc, bit ph, int off);
        real v;
        int  s;
        v = 127.0 * $cos(2.0 * 3.14159265358979323846 * real'((acc >> 8) & 255) / 256.0);
        s = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
        if (ph) s = -s;
        s = s >>> sc;
        s = s + off;
        if (s > 127)  s = 127;
        if (s < -128) s = -128;
        return s + 128;
    endfunction

    function automatic int off_code(logic [7:0] o);
        return int'({~o[7], o[6:0]});
    endfunction

    // Wait for the next strobe, check the interval and the sample, then advance the model phase.
    task automatic take_sample(inout int acc_m, input string tag);
        int gap;
        int exp;
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!dac_valid);
        check(gap == int'(div_sel) + 1, "R3 strobe interval", gap, int'(div_sel) + 1);
        exp = model_code(acc_m, int'(scale_sel), phase_inv, int'($signed(dc_offset)));
        check(int'(dac_code) == exp, tag, int'(dac_code), exp);
        acc_m = (acc_m + int'(freq_step)) & 16'hFFFF;
    endtask

    task automatic start(input vec_t v);
        @(negedge clk);
        enable    = 1'b0;
        freq_step = v.step;
        div_sel   = v.div;
        scale_sel = v.sc;
        phase_inv = v.ph;
        dc_offset = v.off;
        @(negedge clk);
        check(int'(dac_code) == off_code(v.off) && !dac_valid, "R2 idle offset code",
              int'(dac_code), off_code(v.off));
        enable = 1'b1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int acc_m;
        string tag;
        rst = 1'b1; enable = 1'b0; freq_step = '0; div_sel = '0;
        scale_sel = '0; phase_inv = 1'b0; dc_offset = 8'd0;
        repeat (3) @(negedge clk);
        check(dac_code == 8'd128 && !dac_valid, "R1 reset state", int'(dac_code), 128);
        rst = 1'b0;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            case (i)
                0: tag = "R5 peak sample";
                1: tag = "R6 inverted phase";
                2, 3: tag = "R7 scaled sample";
                default: tag = "R8 clipped sum";
            endcase
            start(VECS[i]);
            acc_m = 0;
            take_sample(acc_m, tag);
            check(dac_code == VECS[i].first, "R5 first sample at index 0",
                  int'(dac_code), int'(VECS[i].first));
            for (int n = 1; n < 8; n++) take_sample(acc_m, "R4 phase sequence");
        end

        // Step, offset and scale changed between ticks of a divided clock
        start('{16'h0300, 3'd2, 2'd1, 1'b0, 8'd5, 8'd0});
        acc_m = 0;
        for (int n = 0; n < 3; n++) take_sample(acc_m, "R4 before change");
        freq_step = 16'h0D00;
        dc_offset = 8'hE0;
        scale_sel = 2'd0;
        for (int n = 0; n < 6; n++) take_sample(acc_m, "R9 after change");

        // Re-enable restarts at the peak with phase cleared
        start('{16'h0700, 3'd0, 2'd0, 1'b0, 8'd0, 8'd0});
        acc_m = 0;
        take_sample(acc_m, "R2 restart at peak");
        check(dac_code == 8'd255, "R2 restart peak code", int'(dac_code), 255);

        // Reset while running
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dac_code == 8'd128 && !dac_valid, "R1 reset mid-run", int'(dac_code), 128);
        rst = 1'b0;
        enable = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule